// File: doc/BRIEF.md
# Bit-Band Alias Access Translator

This block sits between a 32-bit bus master and a word-wide memory or peripheral port. It turns single-bit accesses made through two large alias windows into operations on real words. Each 32-bit word in an alias window stands for exactly one bit of a word in the matching bit-band window. One pair of windows covers SRAM: alias 0x22000000–0x23FFFFFF maps to 0x20000000–0x200FFFFF. The other pair covers peripherals: alias 0x42000000–0x43FFFFFF maps to 0x40000000–0x400FFFFF. Software can then flip one flag with a single store, without a separate read and write in code.

An alias data read is forwarded to the target word, and only the selected bit comes back, in bit 0. An alias data write becomes a locked read-modify-write that changes only that bit. The master is held stalled until the sequence ends. All other accesses pass through untouched, and so do instruction fetches, including fetches that land in an alias window.

The master protocol works like this. The master raises `m_req` and holds every request field steady until it sees `m_ready` high at a clock edge. The port below uses the same rule with `s_req` and `s_ready`.

Top module: `bitband_xlate`

## Requirements
- R1: A data access whose address is outside both alias windows is forwarded unchanged: s_addr equals m_addr, s_we, s_wdata and s_rdata pass straight through, and s_lock stays low.
- R2: For an alias offset A (address minus the alias base 0x22000000 or 0x42000000), the downstream word address is the bit-band base (0x20000000 or 0x40000000) plus ((A >> 7) << 2). The bit index is (A >> 2) & 31. This holds up to the last alias word of each window.
- R3: An alias data read returns the selected bit of the target word in m_rdata[0], with m_rdata[31:1] equal to zero.
- R4: An alias data write uses only m_wdata[0]. The value 1 sets the selected bit and 0 clears it. The other 31 bits of the target word keep their values.
- R5: An alias data write is carried out as exactly two downstream beats to the same word: a read (s_we=0) followed by a write (s_we=1).
- R6: s_lock is high on both beats of a read-modify-write and low on every other downstream beat.
- R7: During a read-modify-write, m_ready stays low until both beats have finished. It then goes high for one cycle, in which no downstream request is made.
- R8: An instruction fetch (m_ifetch=1) to an alias address is forwarded unchanged, with the raw 32-bit word returned and no bit extraction.
- R9: If the read beat of a read-modify-write returns s_err, the write beat is skipped and the target word is left unchanged. m_err is reported high with m_ready. For all other accesses, s_err is passed on as m_err.
- R10: After reset, with no request pending, s_req, s_lock and m_ready are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| m_req | input | 1 | Master request valid |
| m_we | input | 1 | Master write enable |
| m_ifetch | input | 1 | Master access is an instruction fetch |
| m_addr | input | 32 | Master byte address |
| m_wdata | input | 32 | Master write data |
| m_ready | output | 1 | Master access completes this cycle |
| m_rdata | output | 32 | Read data to master |
| m_err | output | 1 | Error flag to master, valid with m_ready |
| s_req | output | 1 | Downstream request valid |
| s_we | output | 1 | Downstream write enable |
| s_addr | output | 32 | Downstream byte address |
| s_wdata | output | 32 | Downstream write data |
| s_lock | output | 1 | Downstream lock, held across a read-modify-write |
| s_rdata | input | 32 | Downstream read data |
| s_ready | input | 1 | Downstream beat completes this cycle |
| s_err | input | 1 | Downstream error, valid with s_ready |

## Verification
The assertions assume that the master holds its request fields steady from the rise of m_req until it sees m_ready, and that the port below raises s_ready only while s_req is high. The bench master task drives each request at a falling edge and keeps every field fixed until it has sampled m_ready. It then drops m_req before the next rising edge, so a finished alias write is never started again. The bench's downstream model makes s_ready from s_req and a random wait count, and raises s_err only together with s_ready.

// File: rtl/bb_pkg.sv
// Package bb_pkg
// Shared types for the bit-band translator: the read-modify-write
// sequencer state. Assumes nothing beyond IEEE 1800-2017.
package bb_pkg;
    typedef enum logic [1:0] {
        RMW_IDLE  = 2'd0,
        RMW_READ  = 2'd1,
        RMW_WRITE = 2'd2,
        RMW_DONE  = 2'd3
    } rmw_state_e;
endpackage

// File: rtl/bb_decode.sv
// Module bb_decode
// Compares an address against NWIN alias windows. On a hit, it returns
// the target word address in the matching bit-band window and the bit index.
// Assumes every alias window is 2**AL_LOG2 bytes, aligned to its size,
// and that the windows do not overlap (the lowest window index wins).
module bb_decode #(
    parameter int ADDR_W  = 32,
    parameter int DATA_W  = 32,
    parameter int AL_LOG2 = 25,
    parameter int NWIN    = 2,
    parameter logic [NWIN*ADDR_W-1:0] AL_BASES = '0,
    parameter logic [NWIN*ADDR_W-1:0] BB_BASES = '0
) (
    input  logic [ADDR_W-1:0]         addr,
    output logic                      hit,
    output logic [ADDR_W-1:0]         tgt_addr,
    output logic [$clog2(DATA_W)-1:0] bit_idx
);
    localparam int BIT_W   = $clog2(DATA_W);
    localparam int BYTE_SH = $clog2(DATA_W / 8);
    localparam int WORD_SH = BYTE_SH + BIT_W;
    localparam int TAG_W   = ADDR_W - AL_LOG2;

    logic [NWIN-1:0]   win_hit;
    logic [ADDR_W-1:0] win_tgt [NWIN];
    logic [ADDR_W-1:0] off_ext;

    // Offset inside an alias window, widened to the address width
    assign off_ext = {{TAG_W{1'b0}}, addr[AL_LOG2-1:0]};

    for (genvar w = 0; w < NWIN; w++) begin : g_win
        // Per-window tag match and target word address
        assign win_hit[w] = (addr[ADDR_W-1:AL_LOG2] ==
                             AL_BASES[w*ADDR_W+AL_LOG2 +: TAG_W]);
        assign win_tgt[w] = BB_BASES[w*ADDR_W +: ADDR_W] +
                            ((off_ext >> WORD_SH) << BYTE_SH);
    end

    // Select the first matching window
    always_comb begin
        tgt_addr = '0;
        for (int w = NWIN - 1; w >= 0; w--) begin
            if (win_hit[w]) tgt_addr = win_tgt[w];
        end
    end

    assign hit     = |win_hit;
    assign bit_idx = addr[BYTE_SH +: BIT_W];
endmodule

// File: rtl/bb_rmw.sv
// Module bb_rmw
// Sequences one locked read-modify-write: it reads the target word,
// updates one bit, writes the word back, then signals done for one cycle.
// Assumes start is raised only while idle is high, and that s_ready
// arrives only for beats this module has requested.
module bb_rmw
    import bb_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      start,
    input  logic [ADDR_W-1:0]         tgt_addr,
    input  logic [$clog2(DATA_W)-1:0] bit_idx,
    input  logic                      bit_val,
    input  logic [DATA_W-1:0]         s_rdata,
    input  logic                      s_ready,
    input  logic                      s_err,
    output logic                      idle,
    output logic                      req,
    output logic                      we,
    output logic [ADDR_W-1:0]         addr,
    output logic [DATA_W-1:0]         wdata,
    output logic                      lock,
    output logic                      done,
    output logic                      err
);
    localparam int BIT_W = $clog2(DATA_W);

    rmw_state_e        state;
    logic [ADDR_W-1:0] addr_q;
    logic [BIT_W-1:0]  bit_q;
    logic              val_q;
    logic [DATA_W-1:0] word_q;
    logic              err_q;
    logic [DATA_W-1:0] mask;

    // Sequencer state and captured operands
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= RMW_IDLE;
            addr_q <= '0;
            bit_q  <= '0;
            val_q  <= 1'b0;
            word_q <= '0;
            err_q  <= 1'b0;
        end else begin
            unique case (state)
                RMW_IDLE: if (start) begin
                    state  <= RMW_READ;
                    addr_q <= tgt_addr;
                    bit_q  <= bit_idx;
                    val_q  <= bit_val;
                    err_q  <= 1'b0;
                end
                RMW_READ: if (s_ready) begin
                    word_q <= s_rdata;
                    err_q  <= s_err;
                    state  <= s_err ? RMW_DONE : RMW_WRITE;
                end
                RMW_WRITE: if (s_ready) begin
                    err_q <= s_err;
                    state <= RMW_DONE;
                end
                RMW_DONE: state <= RMW_IDLE;
                default:  state <= RMW_IDLE;
            endcase
        end
    end

    // Merge the single new bit into the word that was read
    always_comb begin
        mask  = DATA_W'(1) << bit_q;
        wdata = val_q ? (word_q | mask) : (word_q & ~mask);
    end

    assign idle = (state == RMW_IDLE);
    assign req  = (state == RMW_READ) || (state == RMW_WRITE);
    assign we   = (state == RMW_WRITE);
    assign lock = req;
    assign addr = addr_q;
    assign done = (state == RMW_DONE);
    assign err  = err_q;
endmodule

// File: rtl/bitband_xlate.sv
// Module bitband_xlate (top)
// Turns data accesses to the alias windows into single-bit reads, or into
// locked read-modify-writes, of the matching bit-band word. Passes every
// other access and every instruction fetch through unchanged.
// Assumes the master holds its request fields steady until m_ready is high.
module bitband_xlate #(
    parameter int ADDR_W  = 32,
    parameter int DATA_W  = 32,
    parameter int AL_LOG2 = 25,
    parameter logic [ADDR_W-1:0] SRAM_AL_BASE = 32'h2200_0000,
    parameter logic [ADDR_W-1:0] SRAM_BB_BASE = 32'h2000_0000,
    parameter logic [ADDR_W-1:0] PERI_AL_BASE = 32'h4200_0000,
    parameter logic [ADDR_W-1:0] PERI_BB_BASE = 32'h4000_0000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              m_req,
    input  logic              m_we,
    input  logic              m_ifetch,
    input  logic [ADDR_W-1:0] m_addr,
    input  logic [DATA_W-1:0] m_wdata,
    output logic              m_ready,
    output logic [DATA_W-1:0] m_rdata,
    output logic              m_err,
    output logic              s_req,
    output logic              s_we,
    output logic [ADDR_W-1:0] s_addr,
    output logic [DATA_W-1:0] s_wdata,
    output logic              s_lock,
    input  logic [DATA_W-1:0] s_rdata,
    input  logic              s_ready,
    input  logic              s_err
);
    localparam int BIT_W = $clog2(DATA_W);
    localparam int NWIN  = 2;

    logic              hit;
    logic [ADDR_W-1:0] tgt_addr;
    logic [BIT_W-1:0]  bit_idx;
    logic              start;
    logic              rmw_idle, rmw_req, rmw_we, rmw_lock, rmw_done, rmw_err;
    logic [ADDR_W-1:0] rmw_addr;
    logic [DATA_W-1:0] rmw_wdata;

    bb_decode #(
        .ADDR_W  (ADDR_W),
        .DATA_W  (DATA_W),
        .AL_LOG2 (AL_LOG2),
        .NWIN    (NWIN),
        .AL_BASES({PERI_AL_BASE, SRAM_AL_BASE}),
        .BB_BASES({PERI_BB_BASE, SRAM_BB_BASE})
    ) u_decode (
        .addr    (m_addr),
        .hit     (hit),
        .tgt_addr(tgt_addr),
        .bit_idx (bit_idx)
    );

    // A data write that hits an alias window starts a read-modify-write
    assign start = rmw_idle && m_req && hit && m_we && !m_ifetch;

    bb_rmw #(
        .ADDR_W(ADDR_W),
        .DATA_W(DATA_W)
    ) u_rmw (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .tgt_addr(tgt_addr),
        .bit_idx (bit_idx),
        .bit_val (m_wdata[0]),
        .s_rdata (s_rdata),
        .s_ready (s_ready),
        .s_err   (s_err),
        .idle    (rmw_idle),
        .req     (rmw_req),
        .we      (rmw_we),
        .addr    (rmw_addr),
        .wdata   (rmw_wdata),
        .lock    (rmw_lock),
        .done    (rmw_done),
        .err     (rmw_err)
    );

    // Route the request and response between master, sequencer and port
    always_comb begin
        s_req   = m_req;
        s_we    = m_we;
        s_addr  = m_addr;
        s_wdata = m_wdata;
        s_lock  = 1'b0;
        m_ready = s_ready;
        m_rdata = s_rdata;
        m_err   = s_err;
        if (!rmw_idle) begin
            s_req   = rmw_req;
            s_we    = rmw_we;
            s_addr  = rmw_addr;
            s_wdata = rmw_wdata;
            s_lock  = rmw_lock;
            m_ready = rmw_done;
            m_rdata = '0;
            m_err   = rmw_done && rmw_err;
        end else if (hit && !m_ifetch) begin
            if (m_we) begin
                s_req   = 1'b0;
                m_ready = 1'b0;
                m_err   = 1'b0;
            end else begin
                s_we    = 1'b0;
                s_addr  = tgt_addr;
                s_wdata = '0;
                m_rdata = DATA_W'(s_rdata[bit_idx]);
            end
        end
    end
endmodule

// File: rtl/bb_checker.sv
// Module bb_checker
// Temporal checks on the translator's ports, attached to every
// bitband_xlate instance by the bind statement below.
// Assumes the master holds its request fields steady until m_ready.
module bb_checker #(
    parameter int ADDR_W  = 32,
    parameter int AL_LOG2 = 25,
    parameter logic [ADDR_W-1:0] SRAM_AL_BASE = 32'h2200_0000,
    parameter logic [ADDR_W-1:0] PERI_AL_BASE = 32'h4200_0000
) (
    input logic              clk,
    input logic              rst_n,
    input logic              m_req,
    input logic              m_ifetch,
    input logic [ADDR_W-1:0] m_addr,
    input logic              m_ready,
    input logic              s_req,
    input logic              s_we,
    input logic [ADDR_W-1:0] s_addr,
    input logic              s_lock,
    input logic              s_ready,
    input logic              s_err
);
    logic in_alias;
    assign in_alias = (m_addr[ADDR_W-1:AL_LOG2] == SRAM_AL_BASE[ADDR_W-1:AL_LOG2]) ||
                      (m_addr[ADDR_W-1:AL_LOG2] == PERI_AL_BASE[ADDR_W-1:AL_LOG2]);

    a_r1_pass_addr: assert property (@(posedge clk) disable iff (!rst_n)
        (m_req && !in_alias) |-> (s_addr == m_addr && !s_lock));

    a_r8_ifetch_pass: assert property (@(posedge clk) disable iff (!rst_n)
        (m_req && m_ifetch) |-> (s_addr == m_addr && !s_lock));

    a_r5_write_follows_read: assert property (@(posedge clk) disable iff (!rst_n)
        (s_req && s_lock && !s_we && s_ready && !s_err) |=> (s_req && s_we && $stable(s_addr)));

    a_r6_lock_held: assert property (@(posedge clk) disable iff (!rst_n)
        (s_req && s_lock && !s_we && s_ready && !s_err) |=> s_lock);

    a_r7_stall: assert property (@(posedge clk) disable iff (!rst_n)
        s_lock |-> !m_ready);

    a_r7_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (s_req && s_lock && s_we && s_ready) |=> (m_ready && !s_req));

    a_r9_abort_on_err: assert property (@(posedge clk) disable iff (!rst_n)
        (s_req && s_lock && !s_we && s_ready && s_err) |=> (!s_req && m_ready));
endmodule

bind bitband_xlate bb_checker #(
    .ADDR_W      (ADDR_W),
    .AL_LOG2     (AL_LOG2),
    .SRAM_AL_BASE(SRAM_AL_BASE),
    .PERI_AL_BASE(PERI_AL_BASE)
) u_bb_checker (
    .clk     (clk),
    .rst_n   (rst_n),
    .m_req   (m_req),
    .m_ifetch(m_ifetch),
    .m_addr  (m_addr),
    .m_ready (m_ready),
    .s_req   (s_req),
    .s_we    (s_we),
    .s_addr  (s_addr),
    .s_lock  (s_lock),
    .s_ready (s_ready),
    .s_err   (s_err)
);

// File: tb/test_bitband_xlate.sv
// Bench for bitband_xlate: fixed-seed random accesses plus directed corners.
module test_bitband_xlate;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        m_req = 1'b0, m_we = 1'b0, m_ifetch = 1'b0;
    logic [31:0] m_addr = '0, m_wdata = '0;
    logic        m_ready, m_err;
    logic [31:0] m_rdata;
    logic        s_req, s_we, s_lock, s_ready, s_err;
    logic [31:0] s_addr, s_wdata, s_rdata;

    int unsigned n_chk = 0, n_bad = 0, cycles = 0;
    logic [31:0] mem  [128];
    logic [31:0] refm [128];
    logic [1:0]  lat = 0, wcnt = 0;
    logic        err_inj = 1'b0;
    int          beats = 0, locks = 0;
    logic [31:0] b_addr [2];
    logic        b_we   [2];
    logic [31:0] b_wdata;

    always #2 clk = ~clk;  // 250 MHz

    bitband_xlate i_bitband_xlate (.*);

    function automatic int idx(input logic [31:0] a);
        return {a[30], a[7:2]};
    endfunction

    function automatic logic is_al(input logic [31:0] a);
        return a[31:25] == 7'h11 || a[31:25] == 7'h21;
    endfunction

    function automatic logic [31:0] exp_word(input logic [31:0] a);
        logic [31:0] off = a - (a[30] ? 32'h4200_0000 : 32'h2200_0000);
        return (a[30] ? 32'h4000_0000 : 32'h2000_0000) + ((off >> 7) << 2);
    endfunction

    function automatic int exp_bit(input logic [31:0] a);
        return int'(a[6:2]);
    endfunction

    // Downstream memory model with random wait states
    assign s_rdata = mem[idx(s_addr)];
    assign s_ready = s_req && (wcnt == lat);
    assign s_err   = s_ready && err_inj;

    always @(posedge clk) begin
        cycles++;
        if (s_req && s_ready) begin
            if (beats < 2) begin
                b_addr[beats] = s_addr;
                b_we[beats]   = s_we;
            end
            if (s_we) b_wdata = s_wdata;
            beats++;
            if (s_lock) locks++;
            if (s_we && !s_err) mem[idx(s_addr)] = s_wdata;
            wcnt = 0;
        end else if (s_req) begin
            wcnt = wcnt + 1;
        end
    end

    // Watchdog
    always @(posedge clk) begin
        if (cycles > 150000) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual hung expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // One master access, followed by checks against the reference model
    task automatic access(input logic we, input logic ifx, input logic [31:0] a, input logic [31:0] wd);
        logic [31:0] rd, expw, ew;
        logic        er;
        int          i, bt;
        logic        alias_data;
        @(negedge clk);
        beats = 0; locks = 0;
        m_req = 1'b1; m_we = we; m_ifetch = ifx; m_addr = a; m_wdata = wd;
        #1;
        while (!m_ready) begin
            @(negedge clk); #1;
        end
        rd = m_rdata; er = m_err; bt = beats;
        @(negedge clk);
        m_req = 1'b0;
        alias_data = is_al(a) && !ifx;
        i = idx(alias_data ? exp_word(a) : a);
        expw = refm[i];
        chk(er == err_inj, "R9 err flag", 32'(er), 32'(err_inj));
        if (alias_data && we) begin
            // R7: both beats (or only the read on error) done before ready
            chk(bt == (err_inj ? 1 : 2), "R7 beats before ready", bt, err_inj ? 1 : 2);
            chk(beats == (err_inj ? 1 : 2), "R5 beat count", beats, err_inj ? 1 : 2);
            chk(locks == beats, "R6 lock on rmw beats", locks, beats);
            chk(b_addr[0] == exp_word(a) && !b_we[0], "R2 rmw read addr", b_addr[0], exp_word(a));
            if (!err_inj) begin
                ew = wd[0] ? (expw | (32'd1 << exp_bit(a))) : (expw & ~(32'd1 << exp_bit(a)));
                chk(b_addr[1] == exp_word(a) && b_we[1], "R5 rmw write beat", b_addr[1], exp_word(a));
                chk(b_wdata == ew, "R4 merged word", b_wdata, ew);
                refm[i] = ew;
            end
            chk(mem[i] == refm[i], "R9 target word", mem[i], refm[i]);
        end else begin
            chk(beats == 1, "R1 single beat", beats, 1);
            chk(locks == 0, "R6 no lock", locks, 0);
            if (alias_data) begin
                chk(b_addr[0] == exp_word(a), "R2 alias read addr", b_addr[0], exp_word(a));
                chk(rd == 32'(expw[exp_bit(a)]), "R3 alias read bit", rd, 32'(expw[exp_bit(a)]));
            end else begin
                chk(b_addr[0] == a && b_we[0] == we, ifx ? "R8 fetch addr" : "R1 pass addr", b_addr[0], a);
                if (!we && !err_inj)
                    chk(rd == expw, ifx ? "R8 fetch data" : "R1 pass data", rd, expw);
                if (we && !err_inj) refm[i] = wd;
            end
        end
    endtask

    function automatic logic [31:0] rnd_bb(input logic r, input int w);
        return (r ? 32'h4000_0000 : 32'h2000_0000) + 32'(w * 4);
    endfunction

    function automatic logic [31:0] rnd_al(input logic r, input int w, input int b);
        return (r ? 32'h4200_0000 : 32'h2200_0000) + 32'(w * 128 + b * 4);
    endfunction

    initial begin
        void'($urandom(32'd1234));
        for (int k = 0; k < 128; k++) begin
            mem[k]  = $urandom;
            refm[k] = mem[k];
        end
        repeat (3) @(posedge clk);
        @(negedge clk); #1;
        chk(!s_req && !s_lock && !m_ready, "R10 reset idle", {s_req, s_lock, m_ready}, 0);
        rst_n = 1'b1;
        @(negedge clk); #1;
        chk(!s_req && !s_lock && !m_ready, "R10 idle after reset", {s_req, s_lock, m_ready}, 0);

        // Directed corners
        access(1, 0, rnd_al(0, 0, 0), 32'd1);                 // R4 set bit 0
        access(0, 0, rnd_al(0, 0, 0), 32'd0);                 // R3 read back
        access(1, 0, rnd_al(1, 5, 31), 32'hFFFF_FFFE);        // R4 clear bit 31, only bit 0 used
        access(0, 0, rnd_al(1, 5, 31), 32'd0);
        access(1, 0, 32'h23FF_FFFC, 32'd1);                   // R2 last SRAM alias word
        access(0, 0, 32'h43FF_FFFC, 32'd0);                   // R2 last peripheral alias word
        access(0, 1, rnd_al(0, 3, 7), 32'd0);                 // R8 fetch from alias
        err_inj = 1'b1;
        access(1, 0, rnd_al(0, 9, 4), 32'd1);                 // R9 abort on read error
        access(0, 0, rnd_bb(1, 2), 32'd0);                    // R9 pass-through error
        err_inj = 1'b0;
        access(1, 0, rnd_bb(0, 9), 32'hA5A5_5A5A);            // R1 direct write
        access(0, 0, rnd_bb(0, 9), 32'd0);                    // R1 direct read

        // Constrained random mix
        for (int n = 0; n < 400; n++) begin
            logic r = 1'($urandom);
            int   w = int'($urandom % 64);
            int   b = int'($urandom % 32);
            int   kind = int'($urandom % 6);
            lat     = 2'($urandom % 3);
            err_inj = ($urandom % 16) == 0;
            case (kind)
                0: access(0, 0, rnd_bb(r, w), 32'd0);
                1: access(1, 0, rnd_bb(r, w), $urandom);
                2: access(0, 0, rnd_al(r, w, b), 32'd0);
                3: access(1, 0, rnd_al(r, w, b), $urandom);
                4: access(0, 1, rnd_al(r, w, b), 32'd0);
                default: access(0, 1, rnd_bb(r, w), 32'd0);
            endcase
        end
        err_inj = 1'b0;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule